// File: doc/BRIEF.md
# Four-Socket Memory Window Decoder

This block places four byte-wide memory sockets in the uppermost part of a byte address space and answers single-cycle read and write strobes against them. The top socket, number 3, always holds read-only code (it covers the reset vector). Its configured size of one, two or four size units sets the size of every socket. The lower three sockets may be left empty, hold read-only code or act as writable memory, subject to size rules. Each socket's contents live in an internal byte array per socket. A separate preload port fills those arrays, whatever the socket type, before the bus uses them.

A configuration port writes a type code for one socket at a time. A mode port selects narrow layout or wide layout. In narrow layout the four sockets sit one after another. In wide layout two sockets form a 16-bit pair, the even byte going to the lower-numbered socket and the odd byte to the higher-numbered one. One cycle after each strobe the block returns a registered response: a hit flag, the socket that was hit, whether a write was stored, and the read byte. A rejected or mismatched configuration sets a sticky error flag.

Top module: `sockwin`

## Requirements
- R1: After synchronous active-low reset every socket is empty, narrow layout is selected, `cfg_err` is 0 and the response outputs show no hit, no accepted write and read data 0xFF.
- R2: In narrow layout with socket size S and address width A, the window base is 2^A − 4·S. Socket i covers base + i·S up to base + (i+1)·S − 1 and uses byte (address − base − i·S) of its array. `rsp_site` reports i.
- R3: Type codes are 0 = empty, 1/2/3 = read-only of 1/2/4 units, 4/5 = writable of 1/4 units, and 6/7 are invalid. A valid read-only code or code 0 written to socket 3 sets the socket size (for codes 1 to 3) and leaves sockets 0 to 2 empty.
- R4: A writable code (4 or 5) written to socket 3, or an invalid code (6 or 7) written to any socket, changes no configuration and sets `cfg_err`.
- R5: A code 1 to 5 written to socket 0, 1 or 2 takes effect only when socket 3 is configured and the code's size equals the current socket size. Otherwise that socket becomes empty and `cfg_err` is set. This means writable sockets are impossible at the 2-unit size.
- R6: A read that hits no configured socket returns 0xFF with `rsp_hit` low.
- R7: A write that hits a writable socket stores the byte and raises `rsp_wr_ok`. A write that hits a read-only socket leaves its contents unchanged and keeps `rsp_wr_ok` low. A strobe with both read and write high acts as a write.
- R8: In wide layout the window is the same 4·S bytes. It is split into two pairs of 2·S bytes, with pair p holding sockets 2p (even addresses) and 2p+1 (odd addresses). The byte index is (offset within the pair) / 2.
- R9: `cfg_err` stays set until reset or the next accepted configuration write, which clears it.
- R10: Responses appear on the cycle after the strobe. A cycle with no strobe is followed by `rsp_hit` = 0 and `rsp_wr_ok` = 0.
- R11: A preload write stores its byte into the chosen socket's array at the given index, whatever the socket type. While `pre_we` is high, bus strobes are ignored and give no hit.
- R12: Code 0 written to socket 0, 1 or 2 empties that socket without raising `cfg_err`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_site | input | 2 | Socket that the configuration write targets |
| cfg_kind | input | 3 | Type code (R3) |
| mode_we | input | 1 | Layout write strobe |
| mode_wide | input | 1 | 1 = wide paired layout, 0 = narrow |
| pre_we | input | 1 | Preload write strobe |
| pre_site | input | 2 | Socket to preload |
| pre_addr | input | STORE_AW | Byte index inside the socket array |
| pre_data | input | DATA_W | Preload byte |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | DATA_W | Write byte |
| rsp_hit | output | 1 | Previous strobe hit a configured socket |
| rsp_site | output | 2 | Socket that was hit |
| rsp_wr_ok | output | 1 | Previous write was stored |
| rsp_rdata | output | DATA_W | Read byte, or 0xFF on a miss |
| cfg_err | output | 1 | Sticky configuration error |

## Verification
The bench builds the block with a 12-bit address, a 32-byte size unit and 7-bit socket arrays. With these values the whole 4096-byte space can be swept address by address, and every array byte is distinct, with no aliasing. Each socket size and both layouts are swept in full. This covers every socket boundary, the window base and every address below it. Writes across the whole window, configuration rejections and a preload that collides with a strobe are checked against an arithmetic model of the address map.

// File: rtl/sockwin_pkg.sv
// Shared type codes and helpers for the four-socket memory window.
// Assumes a 3-bit type code; codes above 5 are invalid.
package sockwin_pkg;
    localparam logic [2:0] KIND_EMPTY  = 3'd0;
    localparam logic [2:0] KIND_ROM_1U = 3'd1;
    localparam logic [2:0] KIND_ROM_2U = 3'd2;
    localparam logic [2:0] KIND_ROM_4U = 3'd3;
    localparam logic [2:0] KIND_RAM_1U = 3'd4;
    localparam logic [2:0] KIND_RAM_4U = 3'd5;

    localparam logic [1:0] TOP_SITE = 2'd3;

    // Size code carried by a type code: 0 = 1 unit, 1 = 2 units, 2 = 4 units.
    function automatic logic [1:0] kind_size(input logic [2:0] kind);
        case (kind)
            KIND_ROM_2U:              return 2'd1;
            KIND_ROM_4U, KIND_RAM_4U: return 2'd2;
            default:                  return 2'd0;
        endcase
    endfunction

    function automatic logic kind_is_ram(input logic [2:0] kind);
        return (kind == KIND_RAM_1U) || (kind == KIND_RAM_4U);
    endfunction

    function automatic logic kind_valid(input logic [2:0] kind);
        return kind <= KIND_RAM_4U;
    endfunction
endpackage

// File: rtl/sockwin_cfg.sv
// Configuration state of the four sockets: per-socket used/writable bits,
// the shared size code, the layout flag and the sticky error flag.
// Assumes at most one configuration write per cycle; socket 3 is the top.
module sockwin_cfg
    import sockwin_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cfg_we,
    input  logic [1:0] cfg_site,
    input  logic [2:0] cfg_kind,
    input  logic       mode_we,
    input  logic       mode_wide,
    output logic [3:0] used,
    output logic [3:0] ram,
    output logic [1:0] szc,
    output logic       wide,
    output logic       err
);
    logic top_sel;
    logic size_match;

    // Classify the incoming request against the current top socket.
    always_comb begin
        top_sel    = (cfg_site == TOP_SITE);
        size_match = used[TOP_SITE] && (kind_size(cfg_kind) == szc);
    end

    // Apply configuration and layout writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            used <= '0;
            ram  <= '0;
            szc  <= 2'd0;
            wide <= 1'b0;
            err  <= 1'b0;
        end else begin
            if (mode_we)
                wide <= mode_wide;
            if (cfg_we) begin
                if (!kind_valid(cfg_kind)) begin
                    err <= 1'b1;
                end else if (top_sel) begin
                    if (kind_is_ram(cfg_kind)) begin
                        err <= 1'b1;
                    end else begin
                        used[2:0]      <= '0;
                        ram            <= '0;
                        used[TOP_SITE] <= (cfg_kind != KIND_EMPTY);
                        if (cfg_kind != KIND_EMPTY)
                            szc <= kind_size(cfg_kind);
                        err <= 1'b0;
                    end
                end else if (cfg_kind == KIND_EMPTY) begin
                    used[cfg_site] <= 1'b0;
                    ram[cfg_site]  <= 1'b0;
                    err            <= 1'b0;
                end else if (size_match) begin
                    used[cfg_site] <= 1'b1;
                    ram[cfg_site]  <= kind_is_ram(cfg_kind);
                    err            <= 1'b0;
                end else begin
                    used[cfg_site] <= 1'b0;
                    ram[cfg_site]  <= 1'b0;
                    err            <= 1'b1;
                end
            end
        end
    end

    // R4: a writable request on the top socket changes nothing and flags.
    a_r4_top_ram_rejected: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_we && cfg_site == TOP_SITE && kind_is_ram(cfg_kind)
        |=> $stable(used) && $stable(ram) && $stable(szc) && err);

    // R3: an accepted top write leaves the lower sockets empty.
    a_r3_top_clears: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_we && cfg_site == TOP_SITE && cfg_kind <= KIND_ROM_4U
        |=> used[2:0] == 3'b000 && ram == 4'b0000);

    // R5: a lower request with no configured top socket is refused.
    a_r5_no_top_refused: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_we && cfg_site != TOP_SITE && cfg_kind != KIND_EMPTY
        && kind_valid(cfg_kind) && !used[TOP_SITE]
        |=> err && !used[$past(cfg_site)]);

    // R9: an accepted lower write clears the error flag.
    a_r9_err_clears: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_we && cfg_site != TOP_SITE && cfg_kind == KIND_EMPTY |=> !err);

    // R4: the top socket is never writable.
    a_r4_top_not_ram: assert property (@(posedge clk) disable iff (!rst_n)
        !ram[TOP_SITE]);
endmodule

// File: rtl/sockwin_map.sv
// Combinational address map: finds whether an address lies in the window,
// which socket it selects and the byte index inside that socket.
// Assumes UNIT_SHIFT + 4 <= ADDR_W and STORE_AW <= ADDR_W.
module sockwin_map #(
    parameter int ADDR_W     = 20,
    parameter int UNIT_SHIFT = 13,
    parameter int STORE_AW   = 8
) (
    input  logic [ADDR_W-1:0]   addr,
    input  logic [1:0]          szc,
    input  logic                wide,
    output logic                in_window,
    output logic [1:0]          site,
    output logic [STORE_AW-1:0] local_addr
);
    localparam logic [ADDR_W-1:0] ONES = '1;

    int unsigned       ss;
    logic [ADDR_W-1:0] off;

    // Split the address by the current socket size and layout.
    always_comb begin
        ss        = UNIT_SHIFT + int'(szc);
        in_window = ((addr >> (ss + 2)) == (ONES >> (ss + 2)));
        off       = addr & ~(ONES << (ss + 2));
        if (wide) begin
            site       = {off[ss + 1], addr[0]};
            local_addr = STORE_AW'((off & ~(ONES << (ss + 1))) >> 1);
        end else begin
            site       = 2'(off >> ss);
            local_addr = STORE_AW'(off & ~(ONES << ss));
        end
    end
endmodule

// File: rtl/sockwin_bank.sv
// Byte array of one socket with one write port and a registered read port.
// Assumes the caller merges preload and bus writes into a single port.
module sockwin_bank #(
    parameter int STORE_AW = 8,
    parameter int DATA_W   = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                we,
    input  logic [STORE_AW-1:0] waddr,
    input  logic [DATA_W-1:0]   wdata,
    input  logic [STORE_AW-1:0] raddr,
    output logic [DATA_W-1:0]   rdata
);
    localparam int DEPTH = 1 << STORE_AW;

    logic [DATA_W-1:0] mem [DEPTH];

    // Store a byte on write.
    always_ff @(posedge clk) begin
        if (we)
            mem[waddr] <= wdata;
    end

    // Register the read byte every cycle.
    always_ff @(posedge clk) begin
        rdata <= mem[raddr];
    end

    // R11: a write lands at its index.
    a_r11_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> mem[$past(waddr)] == $past(wdata));
endmodule

// File: rtl/sockwin.sv
// Four-socket memory window: decodes bus strobes through the address map,
// guards writes by socket type and returns a registered response.
// Assumes single-cycle strobes; preload takes priority over the bus.
module sockwin
    import sockwin_pkg::*;
#(
    parameter int ADDR_W     = 20,
    parameter int UNIT_SHIFT = 13,
    parameter int STORE_AW   = 8,
    parameter int DATA_W     = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cfg_we,
    input  logic [1:0]          cfg_site,
    input  logic [2:0]          cfg_kind,
    input  logic                mode_we,
    input  logic                mode_wide,
    input  logic                pre_we,
    input  logic [1:0]          pre_site,
    input  logic [STORE_AW-1:0] pre_addr,
    input  logic [DATA_W-1:0]   pre_data,
    input  logic                bus_rd,
    input  logic                bus_wr,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic [DATA_W-1:0]   bus_wdata,
    output logic                rsp_hit,
    output logic [1:0]          rsp_site,
    output logic                rsp_wr_ok,
    output logic [DATA_W-1:0]   rsp_rdata,
    output logic                cfg_err
);
    localparam int SITES = 4;

    logic [3:0]          used, ram;
    logic [1:0]          szc;
    logic                wide;
    logic                in_window;
    logic [1:0]          site;
    logic [STORE_AW-1:0] local_addr;
    logic                strobe, hit_now, wr_go, rd_go, rd_q;
    logic [DATA_W-1:0]   bank_q [SITES];

    sockwin_cfg u_cfg (
        .clk(clk), .rst_n(rst_n),
        .cfg_we(cfg_we), .cfg_site(cfg_site), .cfg_kind(cfg_kind),
        .mode_we(mode_we), .mode_wide(mode_wide),
        .used(used), .ram(ram), .szc(szc), .wide(wide), .err(cfg_err)
    );

    sockwin_map #(.ADDR_W(ADDR_W), .UNIT_SHIFT(UNIT_SHIFT), .STORE_AW(STORE_AW)) u_map (
        .addr(bus_addr), .szc(szc), .wide(wide),
        .in_window(in_window), .site(site), .local_addr(local_addr)
    );

    // Qualify the strobe against the configuration.
    always_comb begin
        strobe  = (bus_rd || bus_wr) && !pre_we;
        hit_now = in_window && used[site];
        wr_go   = strobe && bus_wr && hit_now && ram[site];
        rd_go   = strobe && !bus_wr && hit_now;
    end

    // One array per socket, shared by preload and bus writes.
    for (genvar g = 0; g < SITES; g++) begin : g_bank
        logic                we_g;
        logic [STORE_AW-1:0] wa_g;
        logic [DATA_W-1:0]   wd_g;

        // Select the write source for this socket.
        always_comb begin
            we_g = (pre_we && pre_site == 2'(g)) || (wr_go && site == 2'(g));
            wa_g = pre_we ? pre_addr : local_addr;
            wd_g = pre_we ? pre_data : bus_wdata;
        end

        sockwin_bank #(.STORE_AW(STORE_AW), .DATA_W(DATA_W)) u_bank (
            .clk(clk), .rst_n(rst_n), .we(we_g), .waddr(wa_g), .wdata(wd_g),
            .raddr(local_addr), .rdata(bank_q[g])
        );
    end

    // Register the response of the current strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_hit   <= 1'b0;
            rsp_site  <= 2'd0;
            rsp_wr_ok <= 1'b0;
            rd_q      <= 1'b0;
        end else begin
            rsp_hit   <= strobe && hit_now;
            rsp_site  <= (strobe && hit_now) ? site : 2'd0;
            rsp_wr_ok <= wr_go;
            rd_q      <= rd_go;
        end
    end

    // Open-bus value unless a read hit.
    always_comb begin
        rsp_rdata = rd_q ? bank_q[rsp_site] : '1;
    end

    // R10: no strobe, no response.
    a_r10_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd && !bus_wr |=> !rsp_hit && !rsp_wr_ok);

    // R7: an accepted write always came from a hit.
    a_r7_ok_needs_hit: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_wr_ok |-> rsp_hit);

    // R7: a write to a read-only socket is never accepted.
    a_r7_rom_refuses: assert property (@(posedge clk) disable iff (!rst_n)
        bus_wr && !ram[site] |=> !rsp_wr_ok);

    // R11: preload blocks the bus.
    a_r11_preload_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        pre_we |=> !rsp_hit && !rsp_wr_ok);
endmodule

// File: tb/sockwin_test.sv
`timescale 1ns/1ps
module sockwin_test;
    localparam int AW = 12;
    localparam int US = 5;
    localparam int SAW = 7;
    localparam int SPACE = 1 << AW;
    localparam int DEPTH = 1 << SAW;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           cfg_we = 1'b0;
    logic [1:0]     cfg_site = '0;
    logic [2:0]     cfg_kind = '0;
    logic           mode_we = 1'b0;
    logic           mode_wide = 1'b0;
    logic           pre_we = 1'b0;
    logic [1:0]     pre_site = '0;
    logic [SAW-1:0] pre_addr = '0;
    logic [7:0]     pre_data = '0;
    logic           bus_rd = 1'b0;
    logic           bus_wr = 1'b0;
    logic [AW-1:0]  bus_addr = '0;
    logic [7:0]     bus_wdata = '0;
    logic           rsp_hit, rsp_wr_ok, cfg_err;
    logic [1:0]     rsp_site;
    logic [7:0]     rsp_rdata;

    int total = 0;
    int bad = 0;

    logic [7:0] m_mem [4][DEPTH];
    logic       m_used [4];
    logic       m_ram [4];
    int         m_szc = 0;
    logic       m_wide = 1'b0;
    logic       m_err = 1'b0;

    sockwin #(.ADDR_W(AW), .UNIT_SHIFT(US), .STORE_AW(SAW), .DATA_W(8)) uut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_site(cfg_site),
        .cfg_kind(cfg_kind), .mode_we(mode_we), .mode_wide(mode_wide),
        .pre_we(pre_we), .pre_site(pre_site), .pre_addr(pre_addr),
        .pre_data(pre_data), .bus_rd(bus_rd), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .rsp_hit(rsp_hit),
        .rsp_site(rsp_site), .rsp_wr_ok(rsp_wr_ok), .rsp_rdata(rsp_rdata),
        .cfg_err(cfg_err)
    );

    always #4 clk = ~clk;

    task automatic chk(input logic ok, input string req, input string what,
                       input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Address map from R2 / R8, by subtraction and division.
    task automatic decode(input int a, output logic inw, output int s, output int loc);
        int sz, base, off;
        sz   = (1 << US) << m_szc;
        base = SPACE - 4 * sz;
        inw  = (a >= base);
        off  = a - base;
        if (!inw) begin
            s = 0; loc = 0;
        end else if (m_wide) begin
            s   = 2 * (off / (2 * sz)) + (a % 2);
            loc = (off % (2 * sz)) / 2;
        end else begin
            s   = off / sz;
            loc = off % sz;
        end
    endtask

    task automatic access(input logic rd, input logic wr, input int a,
                          input logic [7:0] wd, input string req);
        logic inw, hit, wok;
        int s, loc;
        logic [7:0] exp_d;
        decode(a, inw, s, loc);
        hit   = inw && m_used[s];
        wok   = wr && hit && m_ram[s];
        exp_d = (hit && rd && !wr) ? m_mem[s][loc] : 8'hFF;
        @(negedge clk);
        bus_rd = rd; bus_wr = wr; bus_addr = AW'(a); bus_wdata = wd;
        @(negedge clk);
        bus_rd = 1'b0; bus_wr = 1'b0;
        chk(rsp_hit == hit, req, $sformatf("hit @%0h", a), rsp_hit, hit);
        if (hit) chk(rsp_site == 2'(s), req, $sformatf("site @%0h", a), rsp_site, s);
        chk(rsp_wr_ok == wok, req, $sformatf("wr_ok @%0h", a), rsp_wr_ok, wok);
        if (rd && !wr) chk(rsp_rdata == exp_d, req, $sformatf("data @%0h", a), rsp_rdata, exp_d);
        if (wok) m_mem[s][loc] = wd;
    endtask

    task automatic sweep_rd(input string req);
        for (int a = 0; a < SPACE; a++) access(1'b1, 1'b0, a, 8'h00, req);
    endtask

    task automatic sweep_wr(input string req);
        int base;
        base = SPACE - 4 * ((1 << US) << m_szc);
        for (int a = base; a < SPACE; a++) access(1'b0, 1'b1, a, 8'(a * 5 + 8'h3C), req);
    endtask

    // Configuration model follows R3, R4, R5, R9, R12.
    task automatic cfg(input int s, input int kind, input string req);
        int sz;
        logic rq_ram;
        sz     = (kind == 2) ? 1 : ((kind == 3 || kind == 5) ? 2 : 0);
        rq_ram = (kind == 4 || kind == 5);
        @(negedge clk);
        cfg_we = 1'b1; cfg_site = 2'(s); cfg_kind = 3'(kind);
        @(negedge clk);
        cfg_we = 1'b0;
        if (kind > 5) begin
            m_err = 1'b1;
        end else if (s == 3) begin
            if (rq_ram) m_err = 1'b1;
            else begin
                for (int i = 0; i < 3; i++) begin m_used[i] = 1'b0; m_ram[i] = 1'b0; end
                m_used[3] = (kind != 0);
                if (kind != 0) m_szc = sz;
                m_err = 1'b0;
            end
        end else if (kind == 0) begin
            m_used[s] = 1'b0; m_ram[s] = 1'b0; m_err = 1'b0;
        end else if (m_used[3] && sz == m_szc) begin
            m_used[s] = 1'b1; m_ram[s] = rq_ram; m_err = 1'b0;
        end else begin
            m_used[s] = 1'b0; m_ram[s] = 1'b0; m_err = 1'b1;
        end
        chk(cfg_err == m_err, req, $sformatf("cfg_err after site %0d kind %0d", s, kind),
            cfg_err, m_err);
    endtask

    task automatic set_wide(input logic w);
        @(negedge clk);
        mode_we = 1'b1; mode_wide = w;
        @(negedge clk);
        mode_we = 1'b0;
        m_wide = w;
    endtask

    task automatic preload(input int s, input int a, input logic [7:0] d);
        @(negedge clk);
        pre_we = 1'b1; pre_site = 2'(s); pre_addr = SAW'(a); pre_data = d;
        @(negedge clk);
        pre_we = 1'b0;
        m_mem[s][a] = d;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        for (int i = 0; i < 4; i++) begin m_used[i] = 1'b0; m_ram[i] = 1'b0; end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk(!rsp_hit, "R1", "rsp_hit", rsp_hit, 0);
        chk(!rsp_wr_ok, "R1", "rsp_wr_ok", rsp_wr_ok, 0);
        chk(rsp_rdata == 8'hFF, "R1", "rsp_rdata", rsp_rdata, 8'hFF);
        chk(!cfg_err, "R1", "cfg_err", cfg_err, 0);
        access(1'b1, 1'b0, SPACE - 1, 8'h00, "R1");
        access(1'b1, 1'b0, 0, 8'h00, "R6");

        // R11: preload every byte of every socket
        for (int s = 0; s < 4; s++)
            for (int a = 0; a < DEPTH; a++) preload(s, a, 8'(s * 61 + a * 7 + 13));

        // R3/R5: 1-unit sockets, mixed types
        cfg(3, 1, "R3");
        cfg(0, 4, "R5");
        cfg(1, 1, "R5");
        cfg(2, 4, "R5");
        sweep_rd("R2");
        // R12: empty one lower socket
        cfg(1, 0, "R12");
        access(1'b1, 1'b0, SPACE - 4 * 32 + 32 + 5, 8'h00, "R12");
        cfg(1, 1, "R12");
        sweep_wr("R7");
        sweep_rd("R7");
        // R7: read and write together act as write
        access(1'b1, 1'b1, SPACE - 4 * 32 + 3, 8'hA5, "R7");
        access(1'b1, 1'b0, SPACE - 4 * 32 + 3, 8'h00, "R7");
        // R10: idle cycle gives no response
        @(negedge clk);
        chk(!rsp_hit && !rsp_wr_ok, "R10", "idle response", {rsp_hit, rsp_wr_ok}, 0);

        // R8: paired layout
        set_wide(1'b1);
        sweep_rd("R8");

        // R11: preload collides with a read strobe
        @(negedge clk);
        pre_we = 1'b1; pre_site = 2'd3; pre_addr = SAW'(5); pre_data = 8'h9E;
        bus_rd = 1'b1; bus_addr = AW'(SPACE - 1);
        @(negedge clk);
        pre_we = 1'b0; bus_rd = 1'b0;
        m_mem[3][5] = 8'h9E;
        chk(!rsp_hit, "R11", "hit during preload", rsp_hit, 0);
        access(1'b1, 1'b0, SPACE - 64 + 11, 8'h00, "R11");

        // R3/R5/R9: 2-unit sockets refuse writable parts
        cfg(3, 2, "R3");
        sweep_rd("R3");
        cfg(0, 4, "R5");
        cfg(1, 5, "R5");
        cfg(1, 2, "R9");
        cfg(2, 1, "R5");
        cfg(2, 2, "R9");
        sweep_rd("R8");
        set_wide(1'b0);
        sweep_rd("R2");

        // 4-unit sockets with writable parts
        cfg(3, 3, "R3");
        cfg(0, 5, "R5");
        cfg(1, 5, "R5");
        cfg(2, 3, "R5");
        sweep_wr("R7");
        sweep_rd("R2");
        set_wide(1'b1);
        sweep_wr("R7");
        sweep_rd("R8");

        // R4: rejected requests keep the configuration
        cfg(3, 4, "R4");
        cfg(0, 7, "R4");
        cfg(3, 6, "R4");
        sweep_rd("R4");
        cfg(2, 0, "R12");
        access(1'b1, 1'b0, SPACE - 2, 8'h00, "R12");

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule